// File: doc/BRIEF.md
# Hot Swap Capability Register with Enumeration Request

This block sits on a hot-swappable board. It holds one 32-bit configuration capability entry that reports and controls the board's insertion and extraction state. A debounced ejector-handle switch marks two kinds of event. When the handle locks after the board is seated, the block records an insertion. When the handle unlocks, before the board moves, it records an extraction. Each event is held in a status bit that software clears by writing a one to it. While any event is pending and software has not masked it, the block pulls a shared, active-low enumeration line. This tells system software to scan the bus.

Software reads the entry to find which board raised the request and what kind of event it was. It then clears the event. After the board has been quiesced, software turns on the blue removal-safe LED through a control bit. The enumeration line is open-drain on the board. The block gives the pad's output enable, and the pad drives a constant low whenever that enable is high. The handle input is asynchronous. It passes through a two-flop synchronizer and a counter debouncer before any event is recorded.

Top module: `hsw_cap_top`

## Requirements
- R1: The read dword is laid out as follows. Bits 7:0 hold the capability ID 0x06. Bits 15:8 hold the parameter NEXT_PTR. Bits 23:16 hold the status byte. Bits 31:24 read as zero.
- R2: The insertion bit (dword bit 23, status bit 7) sets when the filtered handle goes from unlocked to locked (handle_raw_i = 1 means locked).
- R3: The extraction bit (dword bit 22, status bit 6) sets when the filtered handle goes from locked to unlocked.
- R4: enum_oe_o is 1 exactly while the insertion bit or the extraction bit is set and the mask bit (dword bit 17, 1 = mask) is 0.
- R5: A write with cfg_be_i[2] = 1 clears an event bit whose data bit (23 or 22) is 1. An event bit whose data bit is 0 is left unchanged.
- R6: The LED bit (dword bit 19) takes the written data bit on a write with cfg_be_i[2] = 1. led_on_o is 1 exactly when this bit is 1.
- R7: The mask bit (dword bit 17) takes the written data bit on a write with cfg_be_i[2] = 1 and reads back as written.
- R8: After reset the status byte reads 0x08: LED on, no events, unmasked. If the handle is already locked when reset is released, the insertion bit sets once the filter settles.
- R9: A handle level held for fewer than DB_CYCLES consecutive synchronized cycles records no event.
- R10: If an event sets in the same cycle that a write clears it, the event bit ends up set.
- R11: A write with cfg_be_i[2] = 0 leaves the status byte unchanged. Status bits 5, 4, 2 and 0 always read 0.
- R12: Writes never change dword bytes 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| handle_raw_i | input | 1 | Raw ejector handle switch, 1 = locked |
| cfg_wr_i | input | 1 | Configuration write strobe for the capability dword |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Current capability dword |
| enum_oe_o | output | 1 | Output enable of the open-drain enumeration pad (1 = pull low) |
| led_on_o | output | 1 | Removal-safe LED drive, 1 = lit |

## Verification
A lost or spurious event bit shows at the ports within one cycle. It appears in bits 23:22 of the read dword and on the enumeration enable, so the bench compares the whole dword and the enable after every operation. A wrong debouncer count or a synchronizer flaw shifts or drops events. The bench detects this because it checks glitches just below the threshold and a clear that lands on the exact cycle an event is recorded. A corrupted mask or LED bit shows on the next readback and on led_on_o right away.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam logic [7:0] HSW_CAP_ID = 8'h06;

    localparam int INS_BIT = 7;
    localparam int EXT_BIT = 6;
    localparam int LOO_BIT = 3;
    localparam int EIM_BIT = 1;

    typedef struct packed {
        logic ins;
        logic ext;
        logic loo;
        logic eim;
    } hsw_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } hdl_evt_t;

    localparam hsw_state_t HSW_RESET_STATE = '{ins: 1'b0, ext: 1'b0, loo: 1'b1, eim: 1'b0};

    function automatic logic [7:0] pack_status(hsw_state_t s);
        logic [7:0] b;
        b          = '0;
        b[INS_BIT] = s.ins;
        b[EXT_BIT] = s.ext;
        b[LOO_BIT] = s.loo;
        b[EIM_BIT] = s.eim;
        return b;
    endfunction

endpackage

// File: rtl/hsw_handle_filter.sv
module hsw_handle_filter
    import hsw_pkg::*;
#(
    parameter int DB_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw_i,
    output hdl_evt_t evt_o
);
    localparam int CW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DB_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;
    logic          settle;

    // the synchronized level has differed long enough: take it this cycle
    assign settle = (sync_q[1] != level_q) && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (settle) begin
                cnt_q   <= '0;
                level_q <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign evt_o.rise = settle & sync_q[1];
    assign evt_o.fall = settle & ~sync_q[1];

endmodule

// File: rtl/hsw_status_reg.sv
module hsw_status_reg
    import hsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hdl_evt_t   evt_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_byte_i,
    output hsw_state_t st_o
);
    hsw_state_t st_q;
    logic       clr_ins;
    logic       clr_ext;

    assign clr_ins = wr_en_i & wr_byte_i[INS_BIT];
    assign clr_ext = wr_en_i & wr_byte_i[EXT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HSW_RESET_STATE;
        end else begin
            // a new event outranks a clear arriving in the same cycle
            st_q.ins <= evt_i.rise | (st_q.ins & ~clr_ins);
            st_q.ext <= evt_i.fall | (st_q.ext & ~clr_ext);
            if (wr_en_i) begin
                st_q.loo <= wr_byte_i[LOO_BIT];
                st_q.eim <= wr_byte_i[EIM_BIT];
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/hsw_cap_top.sv
module hsw_cap_top
    import hsw_pkg::*;
#(
    parameter int         DB_CYCLES = 16,
    parameter logic [7:0] NEXT_PTR  = 8'h48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        handle_raw_i,
    input  logic        cfg_wr_i,
    input  logic [3:0]  cfg_be_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic        enum_oe_o,
    output logic        led_on_o
);
    hdl_evt_t   hevt;
    hsw_state_t st;
    logic       hdl_rise;
    logic       hdl_fall;
    logic       st_wr;
    logic       unused_wr_bits;

    hsw_handle_filter #(.DB_CYCLES(DB_CYCLES)) filt_i (
        .clk   (clk),
        .rst   (rst),
        .raw_i (handle_raw_i),
        .evt_o (hevt)
    );

    assign hdl_rise = hevt.rise;
    assign hdl_fall = hevt.fall;
    assign st_wr    = cfg_wr_i & cfg_be_i[2];

    hsw_status_reg stat_i (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (hevt),
        .wr_en_i   (st_wr),
        .wr_byte_i (cfg_wdata_i[23:16]),
        .st_o      (st)
    );

    assign cfg_rdata_o = {8'h00, pack_status(st), NEXT_PTR, HSW_CAP_ID};
    assign enum_oe_o   = (st.ins | st.ext) & ~st.eim;
    assign led_on_o    = st.loo;

    assign unused_wr_bits = ^{cfg_wdata_i[31:24], cfg_wdata_i[15:0],
                              cfg_be_i[3], cfg_be_i[1:0]};

endmodule

// File: rtl/hsw_cap_chk.sv
module hsw_cap_chk (
    input logic        clk,
    input logic        rst,
    input logic        evt_rise,
    input logic        evt_fall,
    input logic        cfg_wr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        enum_oe,
    input logic        led_on
);
    a_r2_ins_on_rise: assert property (@(posedge clk) disable iff (rst)
        evt_rise |=> cfg_rdata[23]);

    a_r3_ext_on_fall: assert property (@(posedge clk) disable iff (rst)
        evt_fall |=> cfg_rdata[22]);

    a_r4_enum_pending: assert property (@(posedge clk) disable iff (rst)
        ((cfg_rdata[23] || cfg_rdata[22]) && !cfg_rdata[17]) |-> enum_oe);

    a_r4_enum_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[23] && !cfg_rdata[22]) |-> !enum_oe);

    a_r5_w1c_ins: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_be[2] && cfg_wdata[23] && !evt_rise) |=> !cfg_rdata[23]);

    a_r6_led_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_be[2]) |=> (led_on == $past(cfg_wdata[19])));

    a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_rdata[23:16] == 8'h08));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_rise && cfg_wr && cfg_be[2] && cfg_wdata[23]) |=> cfg_rdata[23]);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!(cfg_wr && cfg_be[2]) && !evt_rise && !evt_fall) |=> $stable(cfg_rdata[23:16]));

endmodule

bind hsw_cap_top hsw_cap_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .evt_rise  (hdl_rise),
    .evt_fall  (hdl_fall),
    .cfg_wr    (cfg_wr_i),
    .cfg_be    (cfg_be_i),
    .cfg_wdata (cfg_wdata_i),
    .cfg_rdata (cfg_rdata_o),
    .enum_oe   (enum_oe_o),
    .led_on    (led_on_o)
);

// File: tb/hsw_cap_top_tb_top.sv
`timescale 1ns/1ps
module hsw_cap_top_tb_top;
    localparam int         DB   = 16;
    localparam logic [7:0] NEXT = 8'h48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        handle = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        enum_oe;
    logic        led_on;

    int checks = 0;
    int errors = 0;

    // reference state
    logic m_ins = 1'b0, m_ext = 1'b0, m_loo = 1'b1, m_eim = 1'b0, m_hdl = 1'b0;

    always #4 clk = ~clk;

    hsw_cap_top #(.DB_CYCLES(DB), .NEXT_PTR(NEXT)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .handle_raw_i (handle),
        .cfg_wr_i     (cfg_wr),
        .cfg_be_i     (cfg_be),
        .cfg_wdata_i  (cfg_wdata),
        .cfg_rdata_o  (cfg_rdata),
        .enum_oe_o    (enum_oe),
        .led_on_o     (led_on)
    );

    function automatic logic [31:0] exp_dword(logic i, logic e, logic l, logic m);
        return {8'h00, i, e, 2'b00, l, 1'b0, m, 1'b0, NEXT, 8'h06};
    endfunction

    function automatic logic exp_enum(logic i, logic e, logic m);
        return (i | e) & ~m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " dword"}, cfg_rdata, exp_dword(m_ins, m_ext, m_loo, m_eim));
        check({req, " enum"}, {31'd0, enum_oe}, {31'd0, exp_enum(m_ins, m_ext, m_eim)});
        check({req, " led"}, {31'd0, led_on}, {31'd0, m_loo});
    endtask

    task automatic do_write(logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        if (be[2]) begin
            m_ins = m_ins & ~d[23];
            m_ext = m_ext & ~d[22];
            m_loo = d[19];
            m_eim = d[17];
        end
    endtask

    task automatic set_handle(logic v);
        @(negedge clk);
        handle = v;
        repeat (DB + 6) @(negedge clk);
        if (v && !m_hdl) m_ins = 1'b1;
        if (!v && m_hdl) m_ext = 1'b1;
        m_hdl = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R8 R1 reset");
        check("R11 reserved status bits", {28'd0, cfg_rdata[21:20], cfg_rdata[18], cfg_rdata[16]}, 32'd0);

        set_handle(1'b1);
        check_all("R2 R4 insertion");

        do_write(32'hFFFF_FFFF, 4'b0000);
        check_all("R11 no byte enable");
        do_write(32'hFFFF_FFFF, 4'b1011);
        check_all("R12 read-only bytes");

        do_write(32'h000A_0000, 4'b0100);
        check_all("R7 R4 R5 mask, zero keeps event");

        do_write(32'h0082_0000, 4'b0100);
        check_all("R5 R6 clear ins, led off");

        // glitch shorter than the debounce window
        @(negedge clk);
        handle = 1'b0;
        repeat (DB - 3) @(negedge clk);
        handle = 1'b1;
        repeat (DB + 6) @(negedge clk);
        check_all("R9 short glitch");

        do_write(32'h0008_0000, 4'b0100);
        set_handle(1'b0);
        check_all("R3 R4 extraction");
        do_write(32'h0048_0000, 4'b0100);
        check_all("R5 clear ext");
        set_handle(1'b1);
        check_all("R2 reinsertion");

        // clear landing on the exact cycle the extraction is recorded
        @(negedge clk);
        handle = 1'b0;
        repeat (DB + 1) @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = 4'b0100; cfg_wdata = 32'h00C8_0000;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        m_ins = 1'b0; m_ext = 1'b1; m_loo = 1'b1; m_eim = 1'b0; m_hdl = 1'b0;
        check_all("R10 set beats clear");
        repeat (DB + 6) @(negedge clk);
        check_all("R10 settled");

        // reset with the handle already locked
        handle = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ins = 1'b0; m_ext = 1'b0; m_loo = 1'b1; m_eim = 1'b0; m_hdl = 1'b0;
        @(negedge clk);
        check_all("R8 reset state with handle locked");
        repeat (DB + 6) @(negedge clk);
        m_ins = 1'b1; m_hdl = 1'b1;
        check_all("R8 insertion after reset");

        for (int k = 0; k < 300; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 7) begin
                do_write($urandom, 4'($urandom_range(0, 15)));
                check_all("R5 R6 R7 R11 R12 random write");
            end else begin
                set_handle(~m_hdl);
                check_all("R2 R3 R4 random handle");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule